// File: doc/BRIEF.md
# I2C Slave Address Recognition Engine

This block is the receive front end of an I2C slave. It resynchronises the bus clock and data lines into the system clock domain, spots START and STOP conditions, shifts in each byte, and decides what happens in the acknowledge slot that follows the byte. It drives the bus only through two pull-low enables, one for SDA and one for SCL, so the bus stays open-drain.

In hardware recognition mode the engine compares the first address byte against a programmed own address, in 7-bit or 10-bit form. It also recognises the all-zero general call and the START byte, and reports the outcome through match, general-call and read/write flags and a one-cycle match interrupt. Once addressed, each data byte is handed to the host, and SCL is held low until the host reads it. In software recognition mode no matching is done: every byte, address bytes included, is offered to the host, and SCL stays low in the acknowledge slot until the host writes its ACK/NACK decision.

Top module: `i2c_addr_slave`

## Requirements
- R1: A STOP, or a START seen in any state (repeated START included), returns the engine to waiting for an address byte and clears matchFlag and gcaFlag. After reset every output is 0.
- R2: With tenBitMode=0 in hardware mode, a first byte whose bits [7:1] equal ownAddr[6:0] is acknowledged (SDA pulled low in the ACK slot), sets matchFlag and pulses irqMatch, whatever nakBit holds.
- R3: With tenBitMode=1, a first byte of binary 11110 followed by ownAddr[9:8] and the R/W bit is acknowledged without a match. A second byte equal to ownAddr[7:0] is then acknowledged and sets matchFlag with an irqMatch pulse. A different second byte is not acknowledged and leaves matchFlag at 0. A 7-bit style address is not matched in this mode.
- R4: A first byte of 0x00 (general call) sets matchFlag and gcaFlag and pulses irqMatch. Its ACK slot is pulled low when nakBit=0 and left released when nakBit=1.
- R5: A first byte of 0x01 (START byte) pulses irqMatch and sets matchFlag, leaves gcaFlag at 0, and is never acknowledged.
- R6: rwFlag takes bit 0 (the R/W bit) of the first byte after each START.
- R7: In hardware mode after a match, each data byte is loaded into rxData and pulses irqRxReady. SCL is held low in its ACK slot until rxRead is pulsed, and the ACK then follows nakBit as sampled with rxRead (0 gives ACK, 1 gives NACK).
- R8: In hardware mode, after an address that does not match, no byte of that transfer is acknowledged, stretched or reported by an interrupt.
- R9: With swRecog=1, every byte, address included, is loaded into rxData with an irqRxReady pulse. SCL is held low in the ACK slot until ctlWrite is pulsed, SDA then follows nakBit as sampled with ctlWrite, and SCL is released one cycle later.
- R10: With swRecog=1, matchFlag and gcaFlag are never set and irqMatch never pulses, even for a 0x00 byte.
- R11: irqMatch and irqRxReady are single-cycle pulses and never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Sampled SCL bus level |
| sdaIn | input | 1 | Sampled SDA bus level |
| sclDriveLow | output | 1 | Pull SCL low (clock stretch) |
| sdaDriveLow | output | 1 | Pull SDA low (acknowledge) |
| tenBitMode | input | 1 | 1 selects 10-bit own address |
| swRecog | input | 1 | 1 selects software address recognition |
| ownAddr | input | 10 | Own slave address (low 7 bits used in 7-bit mode) |
| nakBit | input | 1 | Host acknowledge control: 0 ACK, 1 NACK |
| ctlWrite | input | 1 | Host control write strobe (software mode release) |
| rxRead | input | 1 | Host receive-data read strobe (hardware mode release) |
| rxData | output | 8 | Last received byte |
| matchFlag | output | 1 | Address matched in this transfer |
| gcaFlag | output | 1 | Matched address was a general call |
| rwFlag | output | 1 | R/W bit of the first address byte |
| irqMatch | output | 1 | Slave address match interrupt pulse |
| irqRxReady | output | 1 | Receive data ready interrupt pulse |

## Verification
The bench builds the engine with its default two-stage synchroniser and drives a bus master whose half bit lasts eight system clocks. That leaves enough margin for the three-cycle detection lag before each acknowledge decision, and also lets a stretched SCL be seen and serviced by a host model. Mode, own address and nakBit are inputs, so the single build reaches 7-bit, 10-bit, general call, START byte and software recognition transfers, along with repeated START and missed-address cases.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int OWN_W  = 10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR1, ST_ADDR2, ST_DATA, ST_SKIP
  } slvState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrBits;
    logic loadRx;
  } dpStrobe_t;

  // events and compare results from datapath to control
  typedef struct packed {
    logic startDet;
    logic stopDet;
    logic sclFall;
    logic byteDone;
    logic rwBit;
    logic zero7;
    logic own7Hit;
    logic tenHdrHit;
    logic tenLowHit;
  } dpStatus_t;
endpackage

// File: rtl/i2cs_datapath.sv
module i2cs_datapath
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [OWN_W-1:0]  ownAddr,
  input  dpStrobe_t         strobe,
  output dpStatus_t         status,
  output logic [BYTE_W-1:0] rxData
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclD, sdaD;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic startDet, stopDet, sclRise, sclFall;

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe[0] <= sclIn;
      sdaPipe[0] <= sdaIn;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        sclPipe[i] <= sclPipe[i-1];
        sdaPipe[i] <= sdaPipe[i-1];
      end
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;
  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (startDet || strobe.clrBits) begin
      bitCnt <= '0;
    end else if (sclRise && bitCnt < CNT_FULL) begin
      shiftReg <= {shiftReg[BYTE_W-2:0], sdaS};
      bitCnt   <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rxData <= '0;
    else if (strobe.loadRx) rxData <= shiftReg;
  end

  always_comb begin
    status.startDet  = startDet;
    status.stopDet   = stopDet;
    status.sclFall   = sclFall;
    status.byteDone  = (bitCnt == CNT_FULL);
    status.rwBit     = shiftReg[0];
    status.zero7     = (shiftReg[7:1] == 7'd0);
    status.own7Hit   = (shiftReg[7:1] == ownAddr[6:0]);
    status.tenHdrHit = (shiftReg[7:3] == 5'b11110) && (shiftReg[2:1] == ownAddr[9:8]);
    status.tenLowHit = (shiftReg == ownAddr[7:0]);
  end
endmodule

// File: rtl/i2cs_control.sv
module i2cs_control
  import i2cs_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  dpStatus_t status,
  input  logic      tenBitMode,
  input  logic      swRecog,
  input  logic      nakBit,
  input  logic      ctlWrite,
  input  logic      rxRead,
  output dpStrobe_t strobe,
  output logic      sdaDriveLow,
  output logic      sclDriveLow,
  output logic      matchFlag,
  output logic      gcaFlag,
  output logic      rwFlag,
  output logic      irqMatch,
  output logic      irqRxReady
);
  slvState_t state;
  logic inAck, ackLow, waitHost, waitIsCtl, settle;
  logic ackEntry, hostGo;

  assign ackEntry = status.sclFall && status.byteDone && !inAck &&
                    (state == ST_ADDR1 || state == ST_ADDR2 || state == ST_DATA);
  assign hostGo   = waitIsCtl ? ctlWrite : rxRead;

  assign strobe.loadRx  = ackEntry && (swRecog || state == ST_DATA);
  assign strobe.clrBits = inAck && !waitHost && status.sclFall;

  assign sdaDriveLow = inAck && ackLow;
  assign sclDriveLow = inAck && (waitHost || settle);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      inAck      <= 1'b0;
      ackLow     <= 1'b0;
      waitHost   <= 1'b0;
      waitIsCtl  <= 1'b0;
      settle     <= 1'b0;
      matchFlag  <= 1'b0;
      gcaFlag    <= 1'b0;
      rwFlag     <= 1'b0;
      irqMatch   <= 1'b0;
      irqRxReady <= 1'b0;
    end else begin
      irqMatch   <= 1'b0;
      irqRxReady <= 1'b0;
      settle     <= 1'b0;
      if (status.stopDet || status.startDet) begin
        state     <= status.startDet ? ST_ADDR1 : ST_IDLE;
        inAck     <= 1'b0;
        ackLow    <= 1'b0;
        waitHost  <= 1'b0;
        matchFlag <= 1'b0;
        gcaFlag   <= 1'b0;
      end else if (inAck) begin
        if (waitHost) begin
          if (hostGo) begin
            ackLow   <= !nakBit;
            waitHost <= 1'b0;
            settle   <= 1'b1;
          end
        end else if (status.sclFall) begin
          inAck  <= 1'b0;
          ackLow <= 1'b0;
        end
      end else if (ackEntry) begin
        inAck  <= 1'b1;
        ackLow <= 1'b0;
        if (state == ST_ADDR1) rwFlag <= status.rwBit;
        if (swRecog) begin
          waitHost   <= 1'b1;
          waitIsCtl  <= 1'b1;
          irqRxReady <= 1'b1;
          state      <= ST_DATA;
        end else begin
          unique case (state)
            ST_ADDR1: begin
              if (status.zero7 && !status.rwBit) begin
                matchFlag <= 1'b1;
                gcaFlag   <= 1'b1;
                irqMatch  <= 1'b1;
                ackLow    <= !nakBit;
                state     <= ST_DATA;
              end else if (status.zero7) begin
                matchFlag <= 1'b1;
                irqMatch  <= 1'b1;
                state     <= ST_SKIP;
              end else if (!tenBitMode && status.own7Hit) begin
                matchFlag <= 1'b1;
                irqMatch  <= 1'b1;
                ackLow    <= 1'b1;
                state     <= ST_DATA;
              end else if (tenBitMode && status.tenHdrHit) begin
                ackLow <= 1'b1;
                state  <= ST_ADDR2;
              end else begin
                state <= ST_SKIP;
              end
            end
            ST_ADDR2: begin
              if (status.tenLowHit) begin
                matchFlag <= 1'b1;
                irqMatch  <= 1'b1;
                ackLow    <= 1'b1;
                state     <= ST_DATA;
              end else begin
                state <= ST_SKIP;
              end
            end
            default: begin
              waitHost   <= 1'b1;
              waitIsCtl  <= 1'b0;
              irqRxReady <= 1'b1;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  input  logic              tenBitMode,
  input  logic              swRecog,
  input  logic [OWN_W-1:0]  ownAddr,
  input  logic              nakBit,
  input  logic              ctlWrite,
  input  logic              rxRead,
  output logic [BYTE_W-1:0] rxData,
  output logic              matchFlag,
  output logic              gcaFlag,
  output logic              rwFlag,
  output logic              irqMatch,
  output logic              irqRxReady
);
  dpStrobe_t dpStrb;
  dpStatus_t dpStat;

  i2cs_datapath #(.SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ownAddr(ownAddr), .strobe(dpStrb), .status(dpStat), .rxData(rxData)
  );

  i2cs_control i_ctl (
    .clk(clk), .rstN(rstN), .status(dpStat),
    .tenBitMode(tenBitMode), .swRecog(swRecog), .nakBit(nakBit),
    .ctlWrite(ctlWrite), .rxRead(rxRead), .strobe(dpStrb),
    .sdaDriveLow(sdaDriveLow), .sclDriveLow(sclDriveLow),
    .matchFlag(matchFlag), .gcaFlag(gcaFlag), .rwFlag(rwFlag),
    .irqMatch(irqMatch), .irqRxReady(irqRxReady)
  );
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic clk,
  input logic rstN,
  input logic swRecog,
  input logic ctlWrite,
  input logic rxRead,
  input logic sclDriveLow,
  input logic matchFlag,
  input logic gcaFlag,
  input logic irqMatch,
  input logic irqRxReady,
  input logic stopDet
);
  // R4: a general call always counts as an address match
  a_r4_gca_implies_match: assert property (@(posedge clk) disable iff (!rstN)
    gcaFlag |-> matchFlag);

  // R10: software recognition never raises the match flag
  a_r10_sw_no_match: assert property (@(posedge clk) disable iff (!rstN)
    (swRecog && $past(swRecog)) |-> !$rose(matchFlag));

  // R11: interrupts are lone single-cycle pulses
  a_r11_irq_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({irqMatch, irqRxReady}));
  a_r11_match_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irqMatch |=> !irqMatch);
  a_r11_rx_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irqRxReady |=> !irqRxReady);

  // R7, R9: a stretch ends only two cycles after a host strobe
  a_r9_release_after_host: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclDriveLow) |-> $past(ctlWrite || rxRead, 2));

  // R1: a STOP clears the per-transfer flags
  a_r1_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (!matchFlag && !gcaFlag));
endmodule

bind i2c_addr_slave i2cs_checker i_chk (
  .clk(clk), .rstN(rstN), .swRecog(swRecog), .ctlWrite(ctlWrite),
  .rxRead(rxRead), .sclDriveLow(sclDriveLow), .matchFlag(matchFlag),
  .gcaFlag(gcaFlag), .irqMatch(irqMatch), .irqRxReady(irqRxReady),
  .stopDet(dpStat.stopDet)
);

// File: tb/test_i2c_addr_slave.sv
module test_i2c_addr_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic tenBitMode = 1'b0, swRecog = 1'b0, nakBit = 1'b0;
  logic ctlWrite = 1'b0, rxRead = 1'b0;
  logic [9:0] ownAddr = 10'h05A;
  logic sclDriveLow, sdaDriveLow, matchFlag, gcaFlag, rwFlag, irqMatch, irqRxReady;
  logic [7:0] rxData;
  wire sclBus = sclM & ~sclDriveLow;
  wire sdaBus = sdaM & ~sdaDriveLow;

  int errors = 0, checks = 0, nMatch = 0, nRx = 0;
  int m0, r0;
  bit acked, stretched;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_addr_slave i_i2c_addr_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclBus), .sdaIn(sdaBus),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .tenBitMode(tenBitMode), .swRecog(swRecog), .ownAddr(ownAddr),
    .nakBit(nakBit), .ctlWrite(ctlWrite), .rxRead(rxRead), .rxData(rxData),
    .matchFlag(matchFlag), .gcaFlag(gcaFlag), .rwFlag(rwFlag),
    .irqMatch(irqMatch), .irqRxReady(irqRxReady)
  );

  always @(posedge clk) begin
    if (irqMatch)   nMatch++;
    if (irqRxReady) nRx++;
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitClk(HALF_BIT);
    sclM = 1'b1; waitClk(HALF_BIT);
    sdaM = 1'b0; waitClk(HALF_BIT);
    sclM = 1'b0; waitClk(HALF_BIT);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitClk(HALF_BIT);
    sclM = 1'b1; waitClk(HALF_BIT);
    sdaM = 1'b1; waitClk(HALF_BIT);
  endtask

  // hostAct: 0 none, 1 control write, 2 data read
  task automatic sendByte(logic [7:0] b, int hostAct, logic nak);
    bit hostDone = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitClk(HALF_BIT);
      sclM = 1'b1; waitClk(HALF_BIT);
      sclM = 1'b0;
    end
    sdaM = 1'b1; waitClk(HALF_BIT);
    sclM = 1'b1;
    stretched = 1'b0;
    while (!sclBus) begin
      @(negedge clk);
      if (sclDriveLow) stretched = 1'b1;
      if (sclDriveLow && hostAct != 0 && !hostDone) begin
        waitClk(2);
        nakBit = nak;
        if (hostAct == 1) ctlWrite = 1'b1; else rxRead = 1'b1;
        @(negedge clk);
        ctlWrite = 1'b0; rxRead = 1'b0;
        hostDone = 1'b1;
      end
    end
    waitClk(HALF_BIT/2);
    acked = !sdaBus;
    waitClk(HALF_BIT/2);
    sclM = 1'b0;
    waitClk(2);
  endtask

  task automatic t_reset();
    chk("R1", "reset sclDriveLow", sclDriveLow, 0);
    chk("R1", "reset sdaDriveLow", sdaDriveLow, 0);
    chk("R1", "reset flags", {matchFlag, gcaFlag, rwFlag}, 0);
    chk("R1", "reset rxData", rxData, 0);
  endtask

  task automatic t_own7();
    tenBitMode = 0; ownAddr = 10'h05A; nakBit = 1'b1;
    m0 = nMatch; r0 = nRx;
    busStart();
    sendByte(8'hB4, 0, 1'b0);
    chk("R2", "own7 ack", acked, 1);
    chk("R2", "own7 match", matchFlag, 1);
    chk("R11", "own7 irqMatch count", nMatch - m0, 1);
    chk("R6", "own7 rw write", rwFlag, 0);
    chk("R2", "own7 no stretch", stretched, 0);
    sendByte(8'h3C, 2, 1'b0);
    chk("R7", "data stretch", stretched, 1);
    chk("R7", "data ack nak0", acked, 1);
    chk("R7", "rxData", rxData, 8'h3C);
    chk("R7", "irqRx count", nRx - r0, 1);
    sendByte(8'hC3, 2, 1'b1);
    chk("R7", "data nack nak1", acked, 0);
    chk("R7", "rxData second", rxData, 8'hC3);
    busStop();
    chk("R1", "stop clears match", matchFlag, 0);
    nakBit = 1'b0;
  endtask

  task automatic t_read();
    busStart();
    sendByte(8'hB5, 0, 1'b0);
    chk("R2", "read addr ack", acked, 1);
    chk("R6", "rw read", rwFlag, 1);
    busStop();
  endtask

  task automatic t_miss();
    m0 = nMatch; r0 = nRx;
    busStart();
    sendByte(8'h22, 0, 1'b0);
    chk("R8", "miss no ack", acked, 0);
    chk("R8", "miss no match", matchFlag, 0);
    sendByte(8'h77, 0, 1'b0);
    chk("R8", "miss data no ack", acked, 0);
    chk("R8", "miss data no stretch", stretched, 0);
    chk("R8", "miss no irq", (nMatch - m0) + (nRx - r0), 0);
    busStop();
  endtask

  task automatic t_gc();
    m0 = nMatch;
    nakBit = 1'b0;
    busStart();
    sendByte(8'h00, 0, 1'b0);
    chk("R4", "gc ack nak0", acked, 1);
    chk("R4", "gc flag", gcaFlag, 1);
    chk("R4", "gc match", matchFlag, 1);
    chk("R4", "gc irqMatch", nMatch - m0, 1);
    busStop();
    chk("R1", "stop clears gca", gcaFlag, 0);
    nakBit = 1'b1;
    busStart();
    sendByte(8'h00, 0, 1'b0);
    chk("R4", "gc nack nak1", acked, 0);
    chk("R4", "gc flag nak1", gcaFlag, 1);
    busStop();
    nakBit = 1'b0;
  endtask

  task automatic t_startByte();
    m0 = nMatch;
    busStart();
    sendByte(8'h01, 0, 1'b0);
    chk("R5", "start byte no ack", acked, 0);
    chk("R5", "start byte gca clear", gcaFlag, 0);
    chk("R5", "start byte match", matchFlag, 1);
    chk("R5", "start byte irqMatch", nMatch - m0, 1);
    chk("R6", "start byte rw", rwFlag, 1);
    busStop();
  endtask

  task automatic t_ten();
    tenBitMode = 1; ownAddr = 10'h2A5;
    m0 = nMatch;
    busStart();
    sendByte(8'hF4, 0, 1'b0);
    chk("R3", "ten header ack", acked, 1);
    chk("R3", "ten header no match", matchFlag, 0);
    sendByte(8'hA5, 0, 1'b0);
    chk("R3", "ten low ack", acked, 1);
    chk("R3", "ten match", matchFlag, 1);
    chk("R3", "ten irqMatch", nMatch - m0, 1);
    busStop();
    busStart();
    sendByte(8'hF4, 0, 1'b0);
    sendByte(8'hA4, 0, 1'b0);
    chk("R3", "ten wrong low no ack", acked, 0);
    chk("R3", "ten wrong low no match", matchFlag, 0);
    busStop();
    busStart();
    sendByte(8'h4A, 0, 1'b0);
    chk("R3", "ten mode ignores 7-bit form", acked, 0);
    busStop();
    tenBitMode = 0; ownAddr = 10'h05A;
  endtask

  task automatic t_restart();
    busStart();
    sendByte(8'hB4, 0, 1'b0);
    chk("R1", "before restart match", matchFlag, 1);
    busStart();
    chk("R1", "restart clears match", matchFlag, 0);
    sendByte(8'h00, 0, 1'b0);
    chk("R1", "restart new address acked", acked, 1);
    chk("R1", "restart gca", gcaFlag, 1);
    busStop();
  endtask

  task automatic t_sw();
    swRecog = 1'b1;
    m0 = nMatch; r0 = nRx;
    busStart();
    sendByte(8'h55, 1, 1'b0);
    chk("R9", "sw addr stretch", stretched, 1);
    chk("R9", "sw addr ack", acked, 1);
    chk("R9", "sw addr rxData", rxData, 8'h55);
    chk("R9", "sw irqRx", nRx - r0, 1);
    sendByte(8'h9E, 1, 1'b1);
    chk("R9", "sw data nack", acked, 0);
    chk("R9", "sw data rxData", rxData, 8'h9E);
    busStop();
    busStart();
    sendByte(8'h00, 1, 1'b0);
    chk("R10", "sw gc acked by host", acked, 1);
    chk("R10", "sw no gca", gcaFlag, 0);
    chk("R10", "sw no match", matchFlag, 0);
    chk("R10", "sw no irqMatch", nMatch - m0, 0);
    busStop();
    swRecog = 1'b0; nakBit = 1'b0;
  endtask

  initial begin
    waitClk(4);
    t_reset();
    rstN = 1'b1;
    waitClk(4);
    t_own7();
    t_read();
    t_miss();
    t_gc();
    t_startByte();
    t_ten();
    t_restart();
    t_sw();
    waitClk(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R7 R9: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule